// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital controller that drives an eight-input successive-approximation converter. Software programs it through a small register window: one control/status register, one power register and four result registers. Writing the control register launches a block of four conversions. Each conversion occupies a fixed slot. At the start of each slot the sequencer drives the input-select lines and a one-cycle start strobe toward the converter. At the last cycle of the slot it captures the 8-bit code the converter returns. When a block of four completes, a polled completion flag rises. There is no interrupt.

Two mode bits shape a block. The first picks one input sampled four times, or a group of four inputs taken in turn. The second picks a single block followed by a stop, or endless scanning. In scanning mode the result registers are rewritten round-robin. A power bit must be set, and a settling time must elapse, before any slot may run. A start requested earlier is held until then. The converter side has fixed timing and no back-pressure. The code input is sampled on the capture cycle with no valid/ready handshake, because the converter always finishes within its slot.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Each conversion slot lasts SLOT_CYCLES (default 32) clocks. `conv_start` is high for exactly the first clock of a slot. `conv_code` is captured on the last clock of the slot.
- R2: A write to address 0 clears the completion flag at the write edge and starts a block. If the block is already allowed to run, its first slot begins on the next clock. The flag (bit 7 at address 0) reads 1 from the edge that ends the fourth slot, which is 129 edges after the write edge.
- R3: With the scan bit (bit 5) at 0, exactly four conversions run and then the sequencer idles until the next write to address 0.
- R4: With the scan bit at 1, blocks repeat without limit. Result register k is rewritten every 4*SLOT_CYCLES clocks, in order 1, 2, 3, 4, and the flag stays set.
- R5: With the multi bit (bit 4) at 0, the input given by bits 2:0 is converted four times. The results fill result registers 1 to 4 (addresses 4 to 7) in order.
- R6: With the multi bit at 1, bit 2 picks the group. At 0 the block converts inputs 0 to 3 into result registers 1 to 4; at 1 it converts inputs 4 to 7. Bits 1:0 have no effect.
- R7: Bit 3 of the control register is a reserved test bit. It has no effect on conversion and reads back as 0.
- R8: No slot runs until the power bit (address 1, bit 0) has been set for SETTLE_CYCLES clocks. A start written earlier waits and then runs. Clearing the power bit halts conversion.
- R9: A write to address 0 during a block abandons the slot in progress and restarts at slot 1. A slot whose last clock coincides with the write does not update its register or the flag.
- R10: Reads have no side effects. Address 0 reads {flag, 0, scan, multi, 0, select[2:0]}, address 1 reads the power bit, and addresses 4 to 7 read result registers 1 to 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, sampled at the rising edge |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| conv_chan | output | 3 | Analog input select toward the converter |
| conv_start | output | 1 | One-clock strobe at the start of each slot |
| conv_code | input | 8 | Code returned by the converter |

## Verification
Two functions can coincide in one clock: a software write that starts a new block, and the final capture of the running block. The bench times a second control write so that its edge is exactly the capture edge of slot 4. It then judges that the flag stays clear and that result register 4 keeps its earlier value, while the restarted block later fills every register with fresh codes. A second collision puts a pending start against a settling delay that has not yet expired. There, the bench counts converter start strobes through a behavioural stub and shows that none runs early.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CODE_W    = 8;
  localparam int CHAN_W    = 3;
  localparam int NUM_SLOTS = 4;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int ADDR_W    = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_PWR  = 3'd1;

  typedef struct packed {
    logic              scan;
    logic              multi;
    logic [CHAN_W-1:0] sel;
  } ctrl_t;
endpackage

// File: rtl/adc_seq_settle.sv
module adc_seq_settle #(
  parameter int SETTLE_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_en,
  output logic ready
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1) + 1;
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (!pwr_en)       cnt <= '0;
    else if (cnt != LIMIT)  cnt <= cnt + 1'b1;
  end

  assign ready = pwr_en && (cnt == LIMIT);
endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
  import adc_seq_pkg::*;
#(
  parameter int SLOT_CYCLES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  input  logic              ready,
  input  logic              scan,
  output logic [SLOT_W-1:0] slot,
  output logic              conv_start,
  output logic              capture,
  output logic              done
);
  localparam int CW = $clog2(SLOT_CYCLES);
  localparam logic [CW-1:0]     LAST_CYC  = CW'(SLOT_CYCLES - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  logic          pending, active;
  logic [CW-1:0] cyc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      active  <= 1'b0;
      done    <= 1'b0;
      cyc     <= '0;
      slot    <= '0;
    end else if (kick) begin
      // a new request wins over anything finishing this cycle
      pending <= 1'b1;
      active  <= 1'b0;
      done    <= 1'b0;
      cyc     <= '0;
      slot    <= '0;
    end else if (!ready) begin
      active  <= 1'b0;
      cyc     <= '0;
      slot    <= '0;
    end else if (pending) begin
      pending <= 1'b0;
      active  <= 1'b1;
    end else if (active) begin
      if (cyc == LAST_CYC) begin
        cyc <= '0;
        if (slot == LAST_SLOT) begin
          slot <= '0;
          done <= 1'b1;
          if (!scan) active <= 1'b0;
        end else begin
          slot <= slot + 1'b1;
        end
      end else begin
        cyc <= cyc + 1'b1;
      end
    end
  end

  assign conv_start = active && (cyc == '0);
  assign capture    = active && ready && !kick && (cyc == LAST_CYC);
endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results
  import adc_seq_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          capture,
  input  logic [SLOT_W-1:0]             slot,
  input  logic [CODE_W-1:0]             code_in,
  output logic [NUM_SLOTS*CODE_W-1:0]   results
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_res
    logic [CODE_W-1:0] r;
    always_ff @(posedge clk) begin
      if (!rst_n)                               r <= '0;
      else if (capture && slot == SLOT_W'(g))   r <= code_in;
    end
    assign results[g*CODE_W +: CODE_W] = r;
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SETTLE_CYCLES = 200,
  parameter int SLOT_CYCLES   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [CHAN_W-1:0] conv_chan,
  output logic              conv_start,
  input  logic [CODE_W-1:0] conv_code
);
  ctrl_t                       ctrl_q;
  logic                        pwr_q;
  logic                        kick, settle_ok, capture, done;
  logic [SLOT_W-1:0]           slot;
  logic [NUM_SLOTS*CODE_W-1:0] results;
  logic                        multi_q;
  logic [CHAN_W-1:0]           sel_q;

  assign kick    = bus_wr && (bus_addr == A_CTRL);
  assign multi_q = ctrl_q.multi;
  assign sel_q   = ctrl_q.sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pwr_q  <= 1'b0;
    end else begin
      if (kick) begin
        ctrl_q.scan  <= bus_wdata[5];
        ctrl_q.multi <= bus_wdata[4];
        ctrl_q.sel   <= bus_wdata[2:0];   // bit 3 reserved, dropped
      end
      if (bus_wr && bus_addr == A_PWR) pwr_q <= bus_wdata[0];
    end
  end

  adc_seq_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_q), .ready(settle_ok)
  );

  adc_seq_engine #(.SLOT_CYCLES(SLOT_CYCLES)) u_engine (
    .clk(clk), .rst_n(rst_n), .kick(kick), .ready(settle_ok),
    .scan(ctrl_q.scan), .slot(slot), .conv_start(conv_start),
    .capture(capture), .done(done)
  );

  adc_seq_results u_results (
    .clk(clk), .rst_n(rst_n), .capture(capture), .slot(slot),
    .code_in(conv_code), .results(results)
  );

  // group mode: top select bit picks the bank, slot index picks the input
  assign conv_chan = ctrl_q.multi ? {ctrl_q.sel[CHAN_W-1], slot} : ctrl_q.sel;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[2]) begin
      bus_rdata = results[bus_addr[1:0]*CODE_W +: CODE_W];
    end else if (bus_addr == A_CTRL) begin
      bus_rdata = {done, 1'b0, ctrl_q.scan, ctrl_q.multi, 1'b0, ctrl_q.sel};
    end else if (bus_addr == A_PWR) begin
      bus_rdata = {7'd0, pwr_q};
    end
  end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int SLOT_CYCLES = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       kick,
  input logic       done,
  input logic       settle_ok,
  input logic       conv_start,
  input logic       multi_q,
  input logic [2:0] sel_q,
  input logic [2:0] conv_chan
);
  logic [7:0] gap;
  logic       seen, clean;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap   <= '0;
      seen  <= 1'b0;
      clean <= 1'b0;
    end else if (conv_start) begin
      gap   <= 8'd1;
      seen  <= 1'b1;
      clean <= !kick && settle_ok;
    end else begin
      if (gap != 8'hFF) gap <= gap + 1'b1;
      if (kick || !settle_ok) clean <= 1'b0;
    end
  end

  assert_slot_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && seen && clean) |-> (gap == 8'(SLOT_CYCLES)));

  assert_flag_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !done);

  assert_single_chan_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !multi_q) |-> (conv_chan == sel_q));

  assert_group_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && multi_q) |-> (conv_chan[2] == sel_q[2]));

  assert_settled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> settle_ok);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.SLOT_CYCLES(SLOT_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .kick(kick), .done(done), .settle_ok(settle_ok),
  .conv_start(conv_start), .multi_q(multi_q), .sel_q(sel_q),
  .conv_chan(conv_chan)
);

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_seq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [2:0] conv_chan;
  logic       conv_start;
  logic [7:0] conv_code;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  adc_seq_ctrl #(.SETTLE_CYCLES(20), .SLOT_CYCLES(32)) u_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_chan(conv_chan),
    .conv_start(conv_start), .conv_code(conv_code)
  );

  // behavioural converter: code = {input, running start count}
  int unsigned stub_n;
  always @(posedge clk) begin
    if (!rst_n) begin
      stub_n    <= 0;
      conv_code <= 8'd0;
    end else if (conv_start) begin
      conv_code <= {conv_chan, stub_n[4:0]};
      stub_n    <= stub_n + 1;
    end
  end

  // {control byte, expected input for slots 1..4}
  localparam logic [19:0] VEC [6] = '{
    {8'h05, 3'd5, 3'd5, 3'd5, 3'd5},
    {8'h10, 3'd0, 3'd1, 3'd2, 3'd3},
    {8'h17, 3'd4, 3'd5, 3'd6, 3'd7},
    {8'h13, 3'd0, 3'd1, 3'd2, 3'd3},
    {8'h0A, 3'd2, 3'd2, 3'd2, 3'd2},
    {8'h07, 3'd7, 3'd7, 3'd7, 3'd7}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic check_results(input string req, input logic [2:0] ch [4], input logic [4:0] base);
    logic [7:0] d;
    for (int i = 0; i < 4; i++) begin
      peek(3'(4 + i), d);
      check(req, d, {ch[i], 5'(base + 5'(i))});
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    logic [7:0] d, old4;
    logic [4:0] base;
    logic [2:0] ch [4];
    int unsigned snap;

    idle(3);
    rst_n = 1'b1;
    idle(1);
    // reset state
    peek(3'd0, d); check("R10 reset ctrl", d, 8'h00);
    peek(3'd1, d); check("R10 reset pwr", d, 8'h00);
    for (int i = 4; i < 8; i++) begin
      peek(3'(i), d); check("R10 reset result", d, 8'h00);
    end
    check("R1 reset strobe", conv_start, 1'b0);

    // R8: start written before power is held pending
    wr(3'd0, 8'h05);
    idle(50);
    check("R8 no slot unpowered", stub_n, 0);
    peek(3'd0, d); check("R8 flag clear", d[7], 1'b0);
    wr(3'd1, 8'h01);
    idle(20);
    check("R8 no slot while settling", stub_n, 0);
    idle(2);
    check("R8 pending start ran", stub_n, 1);
    idle(126);
    peek(3'd0, d); check("R2 flag not early", d[7], 1'b0);
    idle(1);
    peek(3'd0, d); check("R2 flag set", d[7], 1'b1);
    for (int i = 0; i < 4; i++) ch[i] = 3'd5;
    check_results("R1 R5 settle block", ch, 5'd0);
    peek(3'd1, d); check("R10 pwr readback", d, 8'h01);

    // table-driven blocks
    for (int v = 0; v < 6; v++) begin
      base = stub_n[4:0];
      wr(3'd0, VEC[v][19:12]);
      idle(128);
      peek(3'd0, d); check("R2 flag before end", d[7], 1'b0);
      idle(1);
      peek(3'd0, d);
      check("R2 flag at end", d[7], 1'b1);
      check("R7 R10 ctrl readback", d, (VEC[v][19:12] & 8'h37) | 8'h80);
      for (int i = 0; i < 4; i++) ch[i] = VEC[v][11 - 3*i -: 3];
      check_results(VEC[v][16] ? "R6 group" : "R5 single", ch, base);
      check("R3 four conversions", stub_n - base, 4);
      if (v == 0) begin
        idle(40);
        check("R3 stopped", stub_n - base, 4);
      end
    end

    // R9: second write lands on slot 4 capture edge
    peek(3'd7, old4);
    base = stub_n[4:0];
    wr(3'd0, 8'h02);
    idle(127);
    wr(3'd0, 8'h02);
    peek(3'd0, d); check("R9 collision flag", d[7], 1'b0);
    peek(3'd7, d); check("R9 collision result4 kept", d, old4);
    check("R9 collision starts", stub_n - base, 4);
    idle(129);
    peek(3'd0, d); check("R9 restart flag", d[7], 1'b1);
    for (int i = 0; i < 4; i++) ch[i] = 3'd2;
    check_results("R9 restart results", ch, base + 5'd4);

    // R9: abort in slot 2, switch to upper group
    base = stub_n[4:0];
    wr(3'd0, 8'h02);
    idle(40);
    wr(3'd0, 8'h14);
    peek(3'd0, d); check("R2 abort clears flag", d[7], 1'b0);
    idle(128);
    peek(3'd0, d); check("R9 abort flag early", d[7], 1'b0);
    idle(1);
    peek(3'd0, d); check("R9 abort flag", d[7], 1'b1);
    for (int i = 0; i < 4; i++) ch[i] = 3'(4 + i);
    check_results("R9 R6 abort results", ch, base + 5'd2);

    // R4: continuous scanning, lower group, bits 1:0 set
    base = stub_n[4:0];
    wr(3'd0, 8'h33);
    idle(129);
    peek(3'd0, d); check("R4 first flag", d, 8'hB3);
    for (int i = 0; i < 4; i++) ch[i] = 3'(i);
    check_results("R4 R6 first pass", ch, base);
    idle(32);
    peek(3'd4, d); check("R4 result1 refreshed", d, {3'd0, 5'(base + 5'd4)});
    peek(3'd5, d); check("R4 result2 not yet", d, {3'd1, 5'(base + 5'd1)});
    idle(32);
    peek(3'd5, d); check("R4 result2 refreshed", d, {3'd1, 5'(base + 5'd5)});
    peek(3'd0, d); check("R4 flag held", d[7], 1'b1);

    // R8: power off halts scanning
    wr(3'd1, 8'h00);
    idle(5);
    snap = stub_n;
    idle(100);
    check("R8 power off halts", stub_n, snap);

    finish_run();
  end
endmodule